// File: doc/BRIEF.md
# External Bank Select and Wait-State Controller

This block sits between a processor core and its off-chip memory bus. It watches each external access request and turns the high-order bits of the 32-bit word address into one of four bank-select lines or a non-banked select. The bank span is not fixed: a 4-bit size field sets how many words each bank covers, so the bank boundaries move when the field is reprogrammed. Addresses below the start of external space belong to on-chip or multiprocessor space. The block completes those requests at once and never drives a select for them.

Each external access lasts a programmable number of wait states. An external acknowledge can hold the access open beyond that count. A mode field chooses how these two combine: both must be met, the count alone is used, or the acknowledge alone is used. Bank 0 may hold page-mode DRAM. When that option is on, the block drives a column strobe for every bank 0 access. It drives a one-cycle row strobe only when the row part of the address differs from the last bank 0 access.

The core side is a valid/ready handshake. The core raises `req_valid` with a stable `req_addr` and holds both until it sees `req_ready` high on a rising edge. The transfer completes on that edge. The core may present the next request in the following cycle. Configuration inputs are plain levels and may change only while no request is pending.

Top module: `ext_bank_wait_ctrl`

## Requirements
- R1: A request whose address is below 0x0040_0000 asserts no select or DRAM strobe. It sees `req_ready` high in the same cycle it is presented.
- R2: For an address at or above 0x0040_0000, the bank index is (address − 0x0040_0000) >> (cfg_size + 13). Indices 0 to 3 drive `bank_sel[index]`, where bit n is bank n. At most one select line is ever high.
- R3: An external address whose index is 4 or more drives `nb_sel` instead of a bank select.
- R4: For an external access, the select is high from the cycle after the request is presented through the completing cycle (the one with `req_ready` high), and is low in the next cycle.
- R5: In mode 0 or 3, a wait counter is loaded with `cfg_wait` at acceptance and decrements once per access cycle. The access completes in the first access cycle where the counter is zero and `mem_ack` is high.
- R6: In mode 1, every external access lasts exactly cfg_wait+1 access cycles, and `mem_ack` has no effect.
- R7: In mode 2, an access completes in the first access cycle with `mem_ack` high, whatever `cfg_wait` is.
- R8: With `cfg_dram_en` high, `dram_col` is high for the same cycles as `bank_sel[0]` on every bank 0 access.
- R9: The row of an address is its bits [31:9]. `dram_row` pulses high for only the first access cycle of a bank 0 DRAM access. It pulses only when no row is remembered or the row differs from the remembered row. The new row is then remembered.
- R10: Accesses to banks 1 to 3, to the non-banked region or to internal space leave the remembered row unchanged. A cycle with `cfg_dram_en` low forgets the row.
- R11: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents an access |
| req_addr | input | 32 | Word address of the access, held while valid |
| req_ready | output | 1 | Access completes on this edge |
| cfg_size | input | 4 | Bank span exponent; span = 2^(cfg_size+13) words |
| cfg_wait | input | 5 | Programmed wait states |
| cfg_mode | input | 2 | 0/3 wait and ack, 1 wait only, 2 ack only |
| cfg_dram_en | input | 1 | Bank 0 holds page-mode DRAM |
| mem_ack | input | 1 | External acknowledge from the memory side |
| bank_sel | output | 4 | Bank select strobes, bit n = bank n |
| nb_sel | output | 1 | Non-banked region select |
| dram_row | output | 1 | Row strobe pulse for a new DRAM page |
| dram_col | output | 1 | Column strobe for bank 0 DRAM access |

## Verification
The bench aims at addresses that sit exactly on a bank boundary, at the last word of bank 3, and at the top of the address space, at the smallest and largest size field values. A shift off by one or a bad base subtraction shows up as the wrong select, or as a select for an internal address. It runs wait-only accesses with the acknowledge held low, and ack-only accesses with a large wait count. Mixing up the mode decode would then hang the access, or finish it a different number of cycles from the expected count. The DRAM sequence puts a bank 1 access and a disable cycle between bank 0 accesses to the same row. A tracker that updates on every bank, or never forgets its row, would give a missing or an extra row pulse.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned SIZE_W    = 4;
  localparam int unsigned SIZE_BIAS = 13;
  localparam logic [ADDR_W-1:0] EXT_BASE = 32'h0040_0000;

  typedef enum logic [1:0] {
    CMP_BOTH  = 2'd0,
    CMP_WAIT  = 2'd1,
    CMP_ACK   = 2'd2,
    CMP_BOTH2 = 2'd3
  } cmp_mode_e;
endpackage

// File: rtl/ebw_region_decode.sv
module ebw_region_decode
  import ebw_pkg::*;
#(
  parameter int unsigned N_BANKS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              is_ext,
  output logic [N_BANKS-1:0] bank_hit,
  output logic              nb_hit
);
  localparam int unsigned SH_W = $clog2(ADDR_W);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] index;
  logic [SH_W-1:0]   shamt;

  always_comb begin
    is_ext = (addr >= EXT_BASE);
    offset = addr - EXT_BASE;
    shamt  = SH_W'(size) + SH_W'(SIZE_BIAS);
    index  = offset >> shamt;
    nb_hit = is_ext && (index >= ADDR_W'(N_BANKS));
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_hit[b] = is_ext && (index == ADDR_W'(b));
  end
endmodule

// File: rtl/ebw_wait_counter.sv
module ebw_wait_counter #(
  parameter int unsigned WAIT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              run,
  output logic              at_zero
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/ebw_dram_page.sv
module ebw_dram_page #(
  parameter int unsigned ROW_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start_b0,
  input  logic             finish,
  input  logic [ROW_W-1:0] row,
  output logic             row_pulse,
  output logic             col_on
);
  logic             row_valid_q;
  logic [ROW_W-1:0] last_row_q;
  logic             miss;

  assign miss = !row_valid_q || (row != last_row_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_valid_q <= 1'b0;
      last_row_q  <= '0;
      row_pulse   <= 1'b0;
      col_on      <= 1'b0;
    end else begin
      row_pulse <= enable && start_b0 && miss;
      if (!enable) begin
        row_valid_q <= 1'b0;
      end else if (start_b0) begin
        row_valid_q <= 1'b1;
        last_row_q  <= row;
      end
      if (enable && start_b0) col_on <= 1'b1;
      else if (finish)        col_on <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_bank_wait_ctrl.sv
module ext_bank_wait_ctrl
  import ebw_pkg::*;
#(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned WAIT_W  = 5,
  parameter int unsigned COL_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              req_ready,
  input  logic [3:0]        cfg_size,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_dram_en,
  input  logic              mem_ack,
  output logic [N_BANKS-1:0] bank_sel,
  output logic              nb_sel,
  output logic              dram_row,
  output logic              dram_col
);
  localparam int unsigned ROW_W = ADDR_W - COL_W;

  logic              busy_q;
  logic              is_ext;
  logic [N_BANKS-1:0] hit;
  logic              nb_hit;
  logic              start;
  logic              wait_done;
  logic              wait_ok;
  logic              ack_ok;
  logic              finish;
  cmp_mode_e         mode;

  ebw_region_decode #(.N_BANKS(N_BANKS)) u_dec (
    .addr     (req_addr),
    .size     (cfg_size),
    .is_ext   (is_ext),
    .bank_hit (hit),
    .nb_hit   (nb_hit)
  );

  ebw_wait_counter #(.WAIT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (cfg_wait),
    .run      (busy_q),
    .at_zero  (wait_done)
  );

  ebw_dram_page #(.ROW_W(ROW_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_dram_en),
    .start_b0  (start && hit[0]),
    .finish    (finish),
    .row       (req_addr[ADDR_W-1:COL_W]),
    .row_pulse (dram_row),
    .col_on    (dram_col)
  );

  always_comb begin
    mode    = cmp_mode_e'(cfg_mode);
    start   = !busy_q && req_valid && is_ext;
    wait_ok = (mode == CMP_ACK)  || wait_done;
    ack_ok  = (mode == CMP_WAIT) || mem_ack;
    finish  = busy_q && wait_ok && ack_ok;
    req_ready = busy_q ? finish : (req_valid && !is_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      bank_sel <= '0;
      nb_sel   <= 1'b0;
    end else if (start) begin
      busy_q   <= 1'b1;
      bank_sel <= hit;
      nb_sel   <= nb_hit;
    end else if (finish) begin
      busy_q   <= 1'b0;
      bank_sel <= '0;
      nb_sel   <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_bank_wait_ctrl_chk.sv
module ext_bank_wait_ctrl_chk #(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned WAIT_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [31:0]        req_addr,
  input logic               req_ready,
  input logic [WAIT_W-1:0]  cfg_wait,
  input logic [1:0]         cfg_mode,
  input logic               mem_ack,
  input logic [N_BANKS-1:0] bank_sel,
  input logic               nb_sel,
  input logic               dram_row,
  input logic               dram_col
);
  logic        any_sel;
  logic [15:0] acc_cyc;

  assign any_sel = (|bank_sel) || nb_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_cyc <= '0;
    else if (!any_sel) acc_cyc <= '0;
    else               acc_cyc <= acc_cyc + 1'b1;
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_sel, nb_sel}));  // R2

  AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr < 32'h0040_0000) |-> !any_sel);  // R1

  AST_SELECT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && any_sel) |=> !any_sel);  // R4

  AST_WAIT_ONLY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && req_ready && any_sel) |-> (acc_cyc == 16'(cfg_wait)));  // R6

  AST_ACK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'd1 && req_ready && any_sel) |-> mem_ack);  // R5

  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_mode == 2'd0 || cfg_mode == 2'd3) && req_ready && any_sel)
      |-> (acc_cyc >= 16'(cfg_wait)));  // R5

  AST_COL_IN_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    dram_col |-> bank_sel[0]);  // R8

  AST_ROW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dram_row |=> !dram_row);  // R9
endmodule

bind ext_bank_wait_ctrl ext_bank_wait_ctrl_chk #(.N_BANKS(N_BANKS), .WAIT_W(WAIT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_ready (req_ready),
  .cfg_wait  (cfg_wait),
  .cfg_mode  (cfg_mode),
  .mem_ack   (mem_ack),
  .bank_sel  (bank_sel),
  .nb_sel    (nb_sel),
  .dram_row  (dram_row),
  .dram_col  (dram_col)
);

// File: tb/ext_bank_wait_ctrl_tb_top.sv
module ext_bank_wait_ctrl_tb_top;
  localparam longint BASE = 64'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic [3:0]  cfg_size = '0;
  logic [4:0]  cfg_wait = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_dram_en = 1'b0;
  logic        mem_ack = 1'b0;
  logic [3:0]  bank_sel;
  logic        nb_sel;
  logic        dram_row;
  logic        dram_col;

  int errors = 0;
  int checks = 0;
  int ack_kind = 0;
  logic [7:0] lfsr = 8'h5A;

  ext_bank_wait_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .cfg_size(cfg_size), .cfg_wait(cfg_wait),
    .cfg_mode(cfg_mode), .cfg_dram_en(cfg_dram_en), .mem_ack(mem_ack),
    .bank_sel(bank_sel), .nb_sel(nb_sel), .dram_row(dram_row), .dram_col(dram_col)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // acknowledge source: 0 high, 1 low, 2 pseudo-random
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ack_kind)
      0: mem_ack = 1'b1;
      1: mem_ack = 1'b0;
      default: mem_ack = lfsr[0];
    endcase
  end

  // behavioural reference
  bit     m_busy, m_rv, m_rowp, m_col, m_nb;
  int     m_cnt;
  int     m_bank;
  longint m_last;

  function automatic int decode(input longint a, input int sz);
    longint span;
    if (a < BASE) return -1;
    span = 64'd1 << (sz + 13);
    return int'((a - BASE) / span);
  endfunction

  function automatic bit m_done();
    bit w, k;
    w = (cfg_mode == 2) || (m_cnt == 0);
    k = (cfg_mode == 1) || mem_ack;
    return m_busy && w && k;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_rv = 0; m_rowp = 0; m_col = 0; m_nb = 0; m_cnt = 0; m_bank = -1; m_last = 0;
    end else begin
      bit done;
      int d;
      done = m_done();
      m_rowp = 0;
      if (!cfg_dram_en) m_rv = 0;
      if (!m_busy) begin
        d = decode(longint'(req_addr), int'(cfg_size));
        if (req_valid && d >= 0) begin
          m_busy = 1;
          m_cnt  = int'(cfg_wait);
          m_bank = (d < 4) ? d : -1;
          m_nb   = (d >= 4);
          if (d == 0 && cfg_dram_en) begin
            m_col = 1;
            if (!m_rv || m_last != longint'(req_addr >> 9)) m_rowp = 1;
            m_rv = 1;
            m_last = longint'(req_addr >> 9);
          end
        end
      end else if (done) begin
        m_busy = 0; m_bank = -1; m_nb = 0; m_col = 0;
      end else if (m_cnt > 0) begin
        m_cnt--;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] es;
      bit er;
      es = (m_bank >= 0) ? 4'(1 << m_bank) : 4'd0;
      er = m_busy ? m_done() : (req_valid && longint'(req_addr) < BASE);
      chk(bank_sel == es, "R2,R4 bank_sel", bank_sel, es);
      chk(nb_sel == m_nb, "R3 nb_sel", nb_sel, m_nb);
      if (!m_busy)            chk(req_ready == er, "R1 ready", req_ready, er);
      else if (cfg_mode == 1) chk(req_ready == er, "R6 ready", req_ready, er);
      else if (cfg_mode == 2) chk(req_ready == er, "R7 ready", req_ready, er);
      else                    chk(req_ready == er, "R5 ready", req_ready, er);
      chk(dram_col == m_col, "R8 dram_col", dram_col, m_col);
      chk(dram_row == m_rowp, "R9,R10 dram_row", dram_row, m_rowp);
    end
  end

  task automatic access(input logic [31:0] a, output int acc, output bit saw_row);
    int n = 0;
    saw_row = 0;
    @(posedge clk); #2;
    req_valid = 1'b1;
    req_addr  = a;
    do begin
      @(negedge clk);
      n++;
      if (dram_row) saw_row = 1;
    end while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
    acc = n - 1;
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int acc;
    bit rp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({req_ready, bank_sel, nb_sel, dram_row, dram_col} == 8'd0, "R11 reset outputs",
        {req_ready, bank_sel, nb_sel, dram_row, dram_col}, 0);
    rst_n = 1'b1;

    cfg_size = 4'd0; cfg_wait = 5'd2; cfg_mode = 2'd1; ack_kind = 1;
    access(32'h0000_1000, acc, rp);
    chk(acc == 0, "R1 internal latency", acc, 0);
    access(32'h003F_FFFF, acc, rp);
    chk(acc == 0, "R1 top of internal", acc, 0);
    access(32'(BASE), acc, rp);
    chk(acc == 3, "R6 wait-only length ack low", acc, 3);
    access(32'(BASE + 8192), acc, rp);
    access(32'(BASE + 3 * 8192 + 8191), acc, rp);
    access(32'(BASE + 4 * 8192), acc, rp);
    access(32'hFFFF_FFFF, acc, rp);

    cfg_size = 4'd4;
    access(32'(BASE + 2 * (64'd1 << 17) + 5), acc, rp);
    access(32'(BASE + 4 * (64'd1 << 17)), acc, rp);
    cfg_size = 4'd15;
    access(32'h1040_0000, acc, rp);
    access(32'h3040_0000, acc, rp);
    access(32'hFFFF_FFFF, acc, rp);

    cfg_mode = 2'd2; cfg_wait = 5'd7; ack_kind = 0;
    access(32'h0050_0000, acc, rp);
    chk(acc == 1, "R7 ack-only ignores wait", acc, 1);
    ack_kind = 2;
    for (int i = 0; i < 4; i++) access(32'(BASE + i * 64'h100), acc, rp);

    cfg_mode = 2'd0; cfg_wait = 5'd2;
    for (int i = 0; i < 4; i++) begin
      access(32'(BASE + i * 64'h1_0000), acc, rp);
      chk(acc >= 3, "R5 wait and ack minimum", acc, 3);
    end
    cfg_mode = 2'd3; cfg_wait = 5'd4;
    access(32'h2000_0000, acc, rp);
    chk(acc >= 5, "R5 mode 3 minimum", acc, 5);

    cfg_size = 4'd2; cfg_mode = 2'd1; cfg_wait = 5'd1; cfg_dram_en = 1'b1;
    access(32'(BASE + 64'h10), acc, rp);
    chk(rp == 1, "R9 first row opens", rp, 1);
    access(32'(BASE + 64'h20), acc, rp);
    chk(rp == 0, "R9 same row no pulse", rp, 0);
    access(32'(BASE + 64'h8000), acc, rp);
    access(32'h0000_0040, acc, rp);
    access(32'(BASE + 64'h30), acc, rp);
    chk(rp == 0, "R10 other banks keep row", rp, 0);
    access(32'(BASE + 64'h400), acc, rp);
    chk(rp == 1, "R9 new row pulses", rp, 1);
    cfg_dram_en = 1'b0;
    repeat (2) @(posedge clk);
    #2 cfg_dram_en = 1'b1;
    access(32'(BASE + 64'h400), acc, rp);
    chk(rp == 1, "R10 disable forgets row", rp, 1);
    cfg_dram_en = 1'b0;
    access(32'(BASE + 64'h400), acc, rp);
    chk(rp == 0, "R8 no strobes when disabled", rp, 0);

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule